// File: doc/BRIEF.md
# Wait-State Stretched Phase-2 Clock Generator

This block produces the phase-2 clock for a fast processor from a base clock whose period is one half of the nominal CPU cycle. Each base-clock period is one tick. The low half of every CPU cycle has a fixed length. The high half has a minimum length, and that minimum grows in one-tick (half-cycle) steps with the wait-state count supplied by the address decoder. The count is captured when the high half begins. A slow-bus bridge can freeze the clock high for as long as it needs, using a stall request. When the stall is released, the high half ends on the next tick, but never before the programmed minimum has elapsed.

An optional throttle slows internal processor cycles to legacy speed. When it is enabled and both of the processor's address-valid status strobes are low, the high half is stretched to a fixed long length. Address decoding and the bridge itself are outside this block.

Top module: `p2clk_stretch`

## Requirements
- R1: While the reset input is low, and for the two base-clock cycles of reset synchronisation after it rises, `phi2` is low.
- R2: Every low phase of `phi2` lasts exactly `LOW_TICKS` base-clock cycles (default 1).
- R3: With the throttle not applied and no stall, a high phase lasts `wait_half + 1` base-clock cycles, where `wait_half` is the unsigned count of extra half-cycles.
- R4: `wait_half` and the strobes are sampled only at the clock edge on which `phi2` rises. Changes made while `phi2` is high do not affect the length of that high phase.
- R5: If `bridge_stall` is high at an edge that could end a high phase, `phi2` stays high. With the stall released at the edge ending high cycle K, the phase lasts max(K, minimum) cycles.
- R6: `bridge_stall` has no effect during the low phase: the low phase keeps its fixed length.
- R7: When `throttle_en` is 1 and both `status_prog` and `status_data` are 0 at the rising edge, the high phase lasts max(`wait_half + 1`, `THROTTLE_HIGH`) cycles (default 21, giving a 22-tick cycle).
- R8: When `throttle_en` is 0, or either strobe is 1, the throttle has no effect and R3 applies.
- R9: A stall longer than the tick counter's range (the counter saturates) still ends the high phase on the first edge where the stall is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; one period is one half-cycle tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_half | input | WS_W | Extra high-phase ticks requested for the coming access |
| bridge_stall | input | 1 | Holds phi2 high while set |
| status_prog | input | 1 | Processor status strobe: program address valid |
| status_data | input | 1 | Processor status strobe: data address valid |
| throttle_en | input | 1 | Enables slowing of internal cycles to legacy speed |
| phi2 | output | 1 | Generated phase-2 clock, taken from a register |

## Verification
On every cycle, the assertions check the following: the fixed low-phase length, that the high phase never ends before its latched minimum or while a stall is active, that the latched minimum stays stable through a high phase, that the throttle floor is applied, and that a saturated counter does not lose the end of a stall. Only the bench scenarios can show the exact high-phase lengths across the full wait-count sweep. They also show the max(K, minimum) release timing over a range of stall lengths, that mid-phase input changes are ignored, and the strobe combinations that must leave the throttle inactive.

// File: rtl/p2clk_pkg.sv
package p2clk_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } p2_phase_e;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/p2clk_rst_sync.sv
module p2clk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/p2clk_target_sel.sv
module p2clk_target_sel #(
  parameter int unsigned WS_W          = 4,
  parameter int unsigned CNT_W         = 5,
  parameter int unsigned THROTTLE_HIGH = 21
) (
  input  logic [WS_W-1:0]  wait_half,
  input  logic             status_prog,
  input  logic             status_data,
  input  logic             throttle_en,
  output logic [CNT_W-1:0] target,
  output logic             throttle_hit
);

  localparam logic [CNT_W-1:0] THR_T = CNT_W'(THROTTLE_HIGH);

  logic [CNT_W-1:0] base_t;

  always_comb begin
    base_t       = CNT_W'(wait_half) + CNT_W'(1);
    throttle_hit = throttle_en && !status_prog && !status_data;
    if (throttle_hit && (base_t < THR_T)) begin
      target = THR_T;
    end else begin
      target = base_t;
    end
  end

endmodule

// File: rtl/p2clk_phase_seq.sv
module p2clk_phase_seq
  import p2clk_pkg::*;
#(
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned LOW_TICKS = 1
) (
  input  logic             clk,
  input  logic             rst_n_sync,
  input  logic [CNT_W-1:0] target_in,
  input  logic             stall,
  output logic             phi2,
  output logic             rise_now,
  output logic [CNT_W-1:0] target_q
);

  localparam logic [CNT_W-1:0] LOW_T   = CNT_W'(LOW_TICKS);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p2_phase_e        phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] tgt_q, tgt_d;
  logic             cnt_en, tgt_en;

  // next-state logic
  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    tgt_d    = tgt_q;
    rise_now = 1'b0;
    unique case (phase_q)
      PH_LOW: begin
        if (cnt_q >= LOW_T) begin
          phase_d  = PH_HIGH;
          cnt_d    = CNT_ONE;
          tgt_d    = target_in;
          rise_now = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      PH_HIGH: begin
        if ((cnt_q >= tgt_q) && !stall) begin
          phase_d = PH_LOW;
          cnt_d   = CNT_ONE;
        end else if (cnt_q != CNT_MAX) begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      default: begin
        phase_d = PH_LOW;
        cnt_d   = CNT_ONE;
      end
    endcase
    cnt_en = (cnt_d != cnt_q) || (phase_d != phase_q);
    tgt_en = rise_now;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      phase_q <= PH_LOW;
      cnt_q   <= CNT_ONE;
      tgt_q   <= CNT_ONE;
    end else begin
      phase_q <= phase_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      if (tgt_en) begin
        tgt_q <= tgt_d;
      end
    end
  end

  assign phi2     = (phase_q == PH_HIGH);
  assign target_q = tgt_q;

  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!phi2 && (cnt_q < LOW_T)) |=> !phi2); // R2
  AST_LOW_END: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!phi2 && (cnt_q >= LOW_T)) |=> phi2); // R6
  AST_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (phi2 && (cnt_q < tgt_q)) |=> phi2); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (phi2 && stall) |=> phi2); // R5
  AST_TARGET_STABLE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (phi2 && $past(phi2)) |-> $stable(tgt_q)); // R4
  AST_SAT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (phi2 && (cnt_q == CNT_MAX) && !stall) |=> !phi2); // R9

endmodule

// File: rtl/p2clk_stretch.sv
module p2clk_stretch
  import p2clk_pkg::*;
#(
  parameter int unsigned WS_W          = 4,
  parameter int unsigned LOW_TICKS     = 1,
  parameter int unsigned THROTTLE_HIGH = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WS_W-1:0] wait_half,
  input  logic            bridge_stall,
  input  logic            status_prog,
  input  logic            status_data,
  input  logic            throttle_en,
  output logic            phi2
);

  localparam int unsigned MAX_T = imax(imax(2 ** WS_W, THROTTLE_HIGH), LOW_TICKS);
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  logic             rst_n_sync;
  logic [CNT_W-1:0] target_c;
  logic [CNT_W-1:0] target_lat;
  logic             throttle_hit;
  logic             rise_now;

  p2clk_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  p2clk_target_sel #(
    .WS_W          (WS_W),
    .CNT_W         (CNT_W),
    .THROTTLE_HIGH (THROTTLE_HIGH)
  ) u_target_sel (
    .wait_half    (wait_half),
    .status_prog  (status_prog),
    .status_data  (status_data),
    .throttle_en  (throttle_en),
    .target       (target_c),
    .throttle_hit (throttle_hit)
  );

  p2clk_phase_seq #(
    .CNT_W     (CNT_W),
    .LOW_TICKS (LOW_TICKS)
  ) u_phase_seq (
    .clk        (clk),
    .rst_n_sync (rst_n_sync),
    .target_in  (target_c),
    .stall      (bridge_stall),
    .phi2       (phi2),
    .rise_now   (rise_now),
    .target_q   (target_lat)
  );

  AST_THROTTLE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rise_now && throttle_hit) |=> (target_lat >= CNT_W'(THROTTLE_HIGH))); // R7
  AST_NO_THROTTLE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rise_now && !throttle_hit) |=> (target_lat == CNT_W'($past(wait_half)) + CNT_W'(1))); // R8

endmodule

// File: tb/p2clk_stretch_bench.sv
module p2clk_stretch_bench;

  localparam int WS_W      = 4;
  localparam int LOW_TICKS = 1;
  localparam int THR       = 21;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [WS_W-1:0] wait_half;
  logic            bridge_stall;
  logic            status_prog;
  logic            status_data;
  logic            throttle_en;
  logic            phi2;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  p2clk_stretch u_p2clk_stretch (
    .clk          (clk),
    .rst_n        (rst_n),
    .wait_half    (wait_half),
    .bridge_stall (bridge_stall),
    .status_prog  (status_prog),
    .status_data  (status_data),
    .throttle_en  (throttle_en),
    .phi2         (phi2)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // One full low+high cycle. Inputs are applied in the low phase; the stall
  // is released at the negedge of high cycle stall_k (0 = no stall).
  task automatic run_phase(input int ws, input bit thr, input bit sp, input bit sd,
                           input int stall_k, input bit stall_low, input int ws_mid,
                           input int exp_high, input string req);
    int lo;
    int hi;
    @(negedge clk);
    while (!phi2) @(negedge clk);
    while (phi2) begin
      bridge_stall = 1'b0;
      @(negedge clk);
    end
    wait_half    = WS_W'(ws);
    throttle_en  = thr;
    status_prog  = sp;
    status_data  = sd;
    bridge_stall = stall_low;
    lo = 0;
    while (!phi2) begin
      lo++;
      @(negedge clk);
    end
    check({req, " low length (R2/R6)"}, lo, LOW_TICKS);
    hi = 0;
    while (phi2) begin
      hi++;
      bridge_stall = (hi < stall_k);
      if (hi == 1 && ws_mid >= 0) begin
        wait_half   = WS_W'(ws_mid);
        throttle_en = ~thr;
      end
      @(negedge clk);
    end
    bridge_stall = 1'b0;
    check({req, " high length"}, hi, exp_high);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  initial begin : stim
    rst_n        = 1'b0;
    wait_half    = '0;
    bridge_stall = 1'b0;
    status_prog  = 1'b1;
    status_data  = 1'b1;
    throttle_en  = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1 phi2 in reset", int'(phi2), 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check("R1 phi2 during reset sync", int'(phi2), 0);
    end

    // R3: wait-count sweep, no throttle, no stall
    for (int w = 0; w < 16; w++) run_phase(w, 1'b0, 1'b1, 1'b1, 0, 1'b0, -1, w + 1, "R3 sweep");

    // R7: throttle with internal cycle (both strobes 0)
    for (int w = 0; w < 16; w++) run_phase(w, 1'b1, 1'b0, 1'b0, 0, 1'b0, -1, mx(w + 1, THR), "R7 throttle");

    // R8: throttle inactive cases
    for (int w = 0; w < 16; w++) begin
      run_phase(w, 1'b0, 1'b0, 1'b0, 0, 1'b0, -1, w + 1, "R8 thr off");
      run_phase(w, 1'b1, 1'b1, 1'b0, 0, 1'b0, -1, w + 1, "R8 prog strobe");
      run_phase(w, 1'b1, 1'b0, 1'b1, 0, 1'b0, -1, w + 1, "R8 data strobe");
      run_phase(w, 1'b1, 1'b1, 1'b1, 0, 1'b0, -1, w + 1, "R8 both strobes");
    end

    // R5: stall release at cycle k against minimum 4 and 1
    for (int k = 1; k <= 25; k++) begin
      run_phase(3, 1'b0, 1'b1, 1'b1, k, 1'b0, -1, mx(k, 4), "R5 stall ws3");
      run_phase(0, 1'b0, 1'b1, 1'b1, k, 1'b0, -1, mx(k, 1), "R5 stall ws0");
    end

    // R6: stall held through the low phase does not stretch it
    for (int w = 0; w < 16; w += 5) run_phase(w, 1'b0, 1'b1, 1'b1, 0, 1'b1, -1, w + 1, "R6 stall in low");
    run_phase(2, 1'b0, 1'b1, 1'b1, 7, 1'b1, -1, 7, "R6 stall low+high");

    // R4: mid-phase changes ignored, new value used on the next phase
    run_phase(2, 1'b0, 1'b1, 1'b1, 0, 1'b0, 15, 3, "R4 mid change");
    run_phase(15, 1'b0, 1'b1, 1'b1, 0, 1'b0, -1, 16, "R4 next phase");
    run_phase(0, 1'b1, 1'b0, 1'b0, 0, 1'b0, 9, THR, "R4 throttle mid change");

    // R9: stall far beyond counter range
    run_phase(0, 1'b0, 1'b1, 1'b1, 60, 1'b0, -1, 60, "R9 long stall");
    run_phase(5, 1'b1, 1'b0, 1'b0, 200, 1'b0, -1, 200, "R9 long stall thr");
    run_phase(1, 1'b0, 1'b1, 1'b1, 0, 1'b0, -1, 2, "R9 after long stall");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

endmodule